// File: doc/BRIEF.md
# Trigger-Synchronised Two-Source Select Sequencer

This block drives a pair of select lines that take turns choosing between two data sources, so that one shared output line can carry both streams interleaved in time. The select cycle is four clocks long: the first-source select is high for two clocks, then the second-source select is high for two clocks, and the cycle repeats with no further input.

The sequence is aligned to the sources with a short serial pattern on a trigger input. When the trigger is sampled as 1, then 0, then 1 on three consecutive rising edges, the cycle position is reloaded. The reloaded position depends on two active-low configuration straps that default high. One strap swaps the two halves of the cycle (a 180-degree shift). The other advances the cycle by one clock (90 degrees), so that each source is selected in the centre of its steady period rather than in its second half. The straps are read only at the moment of synchronisation.

All sequencer state is held in triplicated flip-flops behind a 2-of-3 majority vote. Every clock rewrites all three copies with the voted next value, so a single upset is corrected at the next edge. A debug flag reports any disagreement between copies. An injection port lets a bench flip single copies to exercise the voting.

Top module: `trig_sel_sequencer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `sel1_o` is 1, `sel2_o` is 0 and `copy_mismatch_o` is 0. Reset places the cycle at position 0.
- R2: When `trig_i` is sampled 1, 0, 1 on three consecutive rising edges, the cycle position after the fourth rising edge counted from the edge that sampled the first 1 is set by the straps. With both straps high this is position 0: `sel1_o` high for that clock and the next.
- R3: Exactly one of `sel1_o` and `sel2_o` is high in every cycle.
- R4: Without a new pattern, the position advances by one every clock through 0, 1, 2, 3 and wraps to 0. `sel1_o` is high at positions 0 and 1, and `sel2_o` is high at positions 2 and 3.
- R5: With `phase_n_i` low and `mode_n_i` high when the pattern is recognised, the synchronised position is 2, so `sel2_o` leads.
- R6: With `mode_n_i` low and `phase_n_i` high, the synchronised position is 1, one clock ahead of the default.
- R7: With both straps low, the synchronised position is 3.
- R8: The straps are read only at the edge that reloads the cycle. Changing them between patterns leaves the running sequence unchanged.
- R9: A new 1-0-1 pattern resynchronises the cycle at any point. Trigger sequences that do not contain 1-0-1 on consecutive edges (for example 1,1,1 or 1,0,0) leave the sequence unchanged.
- R10: `upset_inj_i` holds three fields of 5 bits, one per copy. Copy k uses bits [5k+4:5k]. Within a field, bits [2:0] are the trigger history and bits [4:3] are the cycle position. A set bit inverts that bit of that copy at the next edge. Inverting one copy of any bit never changes `sel1_o` or `sel2_o`.
- R11: After an edge that inverts a single copy, `copy_mismatch_o` is high for exactly one cycle. The next edge restores all copies to the voted value and the flag returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Serial trigger, one bit per rising edge |
| phase_n_i | input | 1 | Active-low strap: swap the halves of the cycle (180 degrees) |
| mode_n_i | input | 1 | Active-low strap: advance the cycle by one clock (90 degrees) |
| upset_inj_i | input | 3*(CNT_W+3) | Per-copy bit inversion for upset testing |
| sel1_o | output | 1 | Select for the first source |
| sel2_o | output | 1 | Select for the second source |
| copy_mismatch_o | output | 1 | High when any two state copies disagree |

## Verification
The selects are decoded directly from the registered position, so each one changes just after the edge that advances it. The bench samples on the falling edge, half a period later. A trigger pattern sampled on edges E0 to E2 reloads the position on E3, and the strap-dependent position appears after E4. The bench therefore checks the selects at the falling edge after E4, and it keeps its own position model in step on every falling edge. An injected inversion lands on the edge after the injection bit is driven. The mismatch flag is checked high at the next falling edge, while the injection bit is cleared, and low one falling edge later, with the selects compared against the model throughout.

// File: rtl/selseq_pkg.sv
package selseq_pkg;
   localparam int unsigned COPIES = 3;
   localparam int unsigned HIST_W = 3;
   localparam logic [HIST_W-1:0] SYNC_PATTERN = 3'b101;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/selseq_tmr_reg.sv
module selseq_tmr_reg
   import selseq_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        d,
   input  logic [COPIES*W-1:0] inj,
   output logic [W-1:0]        q,
   output logic                mismatch
);
   if (W < 1) begin : g_bad_width
      $error("selseq_tmr_reg: W must be at least 1");
   end

   logic [W-1:0] copy_q [COPIES];

   for (genvar k = 0; k < COPIES; k++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) copy_q[k] <= '0;
         else        copy_q[k] <= d ^ inj[k*W +: W];
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_vote
      assign q[b] = vote3(copy_q[0][b], copy_q[1][b], copy_q[2][b]);
   end

   assign mismatch = |((copy_q[0] ^ copy_q[1]) | (copy_q[0] ^ copy_q[2]));
endmodule

// File: rtl/selseq_trig_detect.sv
module selseq_trig_detect
   import selseq_pkg::*;
(
   input  logic              trig,
   input  logic [HIST_W-1:0] hist_q,
   output logic [HIST_W-1:0] hist_d,
   output logic              match
);
   assign hist_d = {hist_q[HIST_W-2:0], trig};
   assign match  = (hist_q == SYNC_PATTERN);
endmodule

// File: rtl/selseq_phase_ctr.sv
module selseq_phase_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             load,
   input  logic             phase_n,
   input  logic             mode_n,
   output logic [CNT_W-1:0] cnt_d,
   output logic             sel1,
   output logic             sel2
);
   localparam int unsigned PERIOD  = 2 ** CNT_W;
   localparam logic [CNT_W-1:0] HALF    = CNT_W'(PERIOD / 2);
   localparam logic [CNT_W-1:0] QUARTER = CNT_W'(PERIOD / 4);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("selseq_phase_ctr: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] landing;
   logic [CNT_W-1:0] reload;

   always_comb begin
      landing = '0;
      if (!phase_n) landing = landing + HALF;
      if (!mode_n)  landing = landing + QUARTER;
      reload  = landing - ONE;
      cnt_d   = load ? reload : cnt_q + ONE;
   end

   assign sel1 = (cnt_q < HALF);
   assign sel2 = (cnt_q >= HALF);
endmodule

// File: rtl/trig_sel_sequencer.sv
module trig_sel_sequencer
   import selseq_pkg::*;
#(
   parameter int unsigned CNT_W = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                trig_i,
   input  logic                                phase_n_i,
   input  logic                                mode_n_i,
   input  logic [COPIES*(CNT_W+HIST_W)-1:0]    upset_inj_i,
   output logic                                sel1_o,
   output logic                                sel2_o,
   output logic                                copy_mismatch_o
);
   localparam int unsigned ST_W = CNT_W + HIST_W;

   logic [HIST_W-1:0] hist_q, hist_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [ST_W-1:0]   st_q, st_d;
   logic              sync_match;

   assign st_d   = {cnt_d, hist_d};
   assign hist_q = st_q[HIST_W-1:0];
   assign cnt_q  = st_q[ST_W-1:HIST_W];

   selseq_trig_detect u_detect (
      .trig   (trig_i),
      .hist_q (hist_q),
      .hist_d (hist_d),
      .match  (sync_match)
   );

   selseq_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .cnt_q   (cnt_q),
      .load    (sync_match),
      .phase_n (phase_n_i),
      .mode_n  (mode_n_i),
      .cnt_d   (cnt_d),
      .sel1    (sel1_o),
      .sel2    (sel2_o)
   );

   selseq_tmr_reg #(.W(ST_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .d        (st_d),
      .inj      (upset_inj_i),
      .q        (st_q),
      .mismatch (copy_mismatch_o)
   );
endmodule

// File: rtl/selseq_checker.sv
module selseq_checker #(
   parameter int unsigned CNT_W = 2,
   parameter int unsigned INJ_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trig_i,
   input logic             phase_n_i,
   input logic             mode_n_i,
   input logic [INJ_W-1:0] upset_inj_i,
   input logic             sel1_o,
   input logic             sel2_o,
   input logic             copy_mismatch_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic             sync_match
);
   localparam int unsigned PERIOD = 2 ** CNT_W;

   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   function automatic logic [CNT_W-1:0] landing(input logic ph_n, input logic md_n);
      logic [CNT_W-1:0] v;
      v = '0;
      if (!ph_n) v = v + CNT_W'(PERIOD / 2);
      if (!md_n) v = v + CNT_W'(PERIOD / 4);
      return v;
   endfunction

   AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel1_o ^ sel2_o)); // R3

   AST_FREE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_match) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd5 && $past(trig_i, 5) && !$past(trig_i, 4) && $past(trig_i, 3))
      |-> (cnt_q == landing($past(phase_n_i, 2), $past(mode_n_i, 2)))); // R2

   AST_SCRUB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_mismatch_o && (upset_inj_i == '0)) |=> !copy_mismatch_o); // R11
endmodule

bind trig_sel_sequencer selseq_checker #(
   .CNT_W (CNT_W),
   .INJ_W (selseq_pkg::COPIES*(CNT_W+selseq_pkg::HIST_W))
) u_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .trig_i          (trig_i),
   .phase_n_i       (phase_n_i),
   .mode_n_i        (mode_n_i),
   .upset_inj_i     (upset_inj_i),
   .sel1_o          (sel1_o),
   .sel2_o          (sel2_o),
   .copy_mismatch_o (copy_mismatch_o),
   .cnt_q           (cnt_q),
   .sync_match      (sync_match)
);

// File: tb/tb_trig_sel_sequencer.sv
module tb_trig_sel_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 2;
   localparam int PERIOD = 4;
   localparam int ST_W   = 5;
   localparam int INJ_W  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0;
   logic phase_n = 1'b1;
   logic mode_n = 1'b1;
   logic [INJ_W-1:0] inj = '0;
   logic sel1, sel2, mism;

   int checks = 0;
   int errors = 0;
   int exp_pos = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_sel_sequencer #(.CNT_W(CNT_W)) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .trig_i          (trig),
      .phase_n_i       (phase_n),
      .mode_n_i        (mode_n),
      .upset_inj_i     (inj),
      .sel1_o          (sel1),
      .sel2_o          (sel2),
      .copy_mismatch_o (mism)
   );

   task automatic check_out(input string req, input logic exp_mm);
      logic e1, e2;
      e1 = (exp_pos < PERIOD/2);
      e2 = !e1;
      checks++;
      if (sel1 !== e1 || sel2 !== e2 || mism !== exp_mm) begin
         errors++;
         $display("FAIL %s: sel1=%b sel2=%b mism=%b expected sel1=%b sel2=%b mism=%b (pos %0d)",
                  req, sel1, sel2, mism, e1, e2, exp_mm, exp_pos);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      exp_pos = (exp_pos + 1) % PERIOD;
   endtask

   task automatic run(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick();
         check_out(req, 1'b0);
      end
   endtask

   function automatic int landing(input logic ph_n, input logic md_n);
      return (ph_n ? 0 : PERIOD/2) + (md_n ? 0 : PERIOD/4);
   endfunction

   task automatic sync(input logic ph_n, input logic md_n, input string req);
      phase_n = ph_n;
      mode_n  = md_n;
      trig = 1'b1; tick(); check_out(req, 1'b0);
      trig = 1'b0; tick(); check_out(req, 1'b0);
      trig = 1'b1; tick(); check_out(req, 1'b0);
      trig = 1'b0; tick();
      exp_pos = (landing(ph_n, md_n) + PERIOD - 1) % PERIOD;
      check_out(req, 1'b0);
      tick();
      check_out(req, 1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      exp_pos = 0;
      check_out("R1 in reset", 1'b0);
      rst_n = 1'b1;
      check_out("R1 after release", 1'b0);
      run(4, "R1/R4 free run from reset");
   endtask

   task automatic t_sync_default();
      sync(1'b1, 1'b1, "R2 default landing");
      run(8, "R4 cycle after default sync");
   endtask

   task automatic t_sync_phase();
      sync(1'b0, 1'b1, "R5 phase swap landing");
      run(4, "R5/R3 cycle after swap");
   endtask

   task automatic t_sync_mode();
      sync(1'b1, 1'b0, "R6 advance landing");
      run(4, "R6/R3 cycle after advance");
   endtask

   task automatic t_sync_both();
      sync(1'b0, 1'b0, "R7 swap plus advance landing");
      run(4, "R7/R3 cycle after both");
   endtask

   task automatic t_static_straps();
      sync(1'b1, 1'b1, "R8 reference sync");
      phase_n = 1'b0; run(3, "R8 phase strap changed");
      mode_n  = 1'b0; run(3, "R8 both straps changed");
      phase_n = 1'b1; mode_n = 1'b1; run(2, "R8 straps restored");
   endtask

   task automatic t_incomplete();
      trig = 1'b1; run(3, "R9 trigger 1,1,1");
      trig = 1'b0; run(2, "R9 trigger 1,0,0");
      run(3, "R9 idle after incomplete");
      run(1, "R9 mid-cycle before resync");
      sync(1'b1, 1'b0, "R9 resync mid-stream");
      run(3, "R9 after resync");
   endtask

   task automatic t_upset(input int bit_idx, input string req);
      inj = '0;
      inj[bit_idx] = 1'b1;
      tick();
      inj = '0;
      check_out({req, " R10/R11 flag after flip"}, 1'b1);
      tick();
      check_out({req, " R11 scrubbed"}, 1'b0);
      run(4, {req, " R10 sequence intact"});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_sync_default();
      t_sync_phase();
      t_sync_mode();
      t_sync_both();
      t_static_straps();
      t_incomplete();
      t_upset(1*ST_W + 3, "counter bit0 copy1");
      t_upset(0*ST_W + 4, "counter bit1 copy0");
      t_upset(2*ST_W + 0, "history bit0 copy2");
      t_upset(1*ST_W + 2, "history bit2 copy1");
      sync(1'b1, 1'b1, "R2 final sync");
      run(2, "R4 final run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule